// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block gives each hart in a cluster one 32-bit word on a simple register bus. Bit 0 of that word drives the hart's software-interrupt line, so any agent on the bus can raise an interrupt in any hart. Hart i owns the word at byte offset 4*i. The block decodes only word-aligned, full-width accesses that fall inside the mapped range. Every other access is dropped.

A mode parameter picks one of two behaviours. In machine mode the word is a level flag: software can read it, and a write of bit 0 sets or clears it. In supervisor mode a bus write can only raise the request, and every read returns zero. The hart lowers its own request through a per-hart clear input. Read data is registered and appears in the cycle after the read request.

Top module: `swi_bank`

## Requirements
- R1: After reset every soft_irq bit is 0 and bus_rdata is 0.
- R2: A write to byte offset 4*i (i below HART_COUNT) affects soft_irq[i] only. Every other hart's bit keeps its value.
- R3: In machine mode, a write with wdata[0]=1 makes soft_irq[i] 1 on the next clock edge. A write with wdata[0]=0 makes it 0 on the next clock edge.
- R4: In machine mode, a read of hart i's word returns {31'b0, soft_irq[i]} on bus_rdata in the cycle after the request.
- R5: In supervisor mode, a write with wdata[0]=1 makes soft_irq[i] 1 on the next edge. A write with wdata[0]=0 leaves it unchanged.
- R6: In supervisor mode, bus_rdata is always 0.
- R7: In supervisor mode, hart_clear[i]=1 makes soft_irq[i] 0 on the next edge. If a set write to hart i arrives in the same cycle, the set wins and the bit becomes 1.
- R8: In machine mode, hart_clear has no effect.
- R9: An access with bus_addr[1:0] not equal to 0 is ignored on write and reads as 0.
- R10: An access at a byte address of HART_COUNT*4 or above is ignored on write and reads as 0.
- R11: An access with bus_be other than 4'hF (all four byte lanes) is ignored on write and reads as 0.
- R12: Bits 31:1 of bus_wdata never affect the state. Only bit 0 is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_be | input | 4 | Byte-lane enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data; bit 0 is the request bit |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| hart_clear | input | HART_COUNT | Per-hart clear of the pending request (supervisor mode) |
| soft_irq | output | HART_COUNT | Per-hart software-interrupt lines |

## Verification
A wrong pending bit shows on soft_irq on the edge after the write that caused it. In machine mode it also shows in bus_rdata one cycle after a read of that word, so every error is visible within two cycles.

Decode faults behave differently. They include a wrong hart index, an accepted misaligned address, partial byte enables, or an out-of-range address. Each of these changes a soft_irq bit that should have held, or returns nonzero read data where zero was due. The bench therefore compares every output against a model of all harts after each access, not only the hart that was addressed.

// File: rtl/swi_pkg.sv
package swi_pkg;
   typedef enum logic {
      MODE_MACHINE    = 1'b0,
      MODE_SUPERVISOR = 1'b1
   } swi_mode_e;

   localparam int unsigned DATA_W  = 32;
   localparam int unsigned LANES   = DATA_W / 8;
   localparam int unsigned WORD_SH = 2;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
   parameter int unsigned HART_COUNT = 4,
   parameter int unsigned ADDR_W     = 8
) (
   input  logic                          bus_valid,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [swi_pkg::LANES-1:0]     bus_be,
   output logic                          hit,
   output logic [HART_COUNT-1:0]         sel
);
   localparam int unsigned WORD_W    = ADDR_W - swi_pkg::WORD_SH;
   localparam logic [ADDR_W:0] MAP_BYTES = (ADDR_W+1)'(HART_COUNT * 4);

   logic aligned, in_range, full_width;

   assign aligned    = (bus_addr[swi_pkg::WORD_SH-1:0] == '0);
   assign in_range   = ({1'b0, bus_addr} < MAP_BYTES);
   assign full_width = (bus_be == '1);
   assign hit        = bus_valid && aligned && in_range && full_width;

   for (genvar i = 0; i < HART_COUNT; i++) begin : g_sel
      assign sel[i] = hit && (bus_addr[ADDR_W-1:swi_pkg::WORD_SH] == WORD_W'(i));
   end
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
   parameter swi_pkg::swi_mode_e MODE = swi_pkg::MODE_MACHINE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_sel,
   input  logic wr_bit,
   input  logic clr,
   output logic pending
);
   logic pending_d;

   if (MODE == swi_pkg::MODE_SUPERVISOR) begin : g_sup
      always_comb begin
         if (wr_sel && wr_bit)  pending_d = 1'b1;
         else if (clr)          pending_d = 1'b0;
         else                   pending_d = pending;
      end

      assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_sel && wr_bit) |=> pending);
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!(wr_sel && wr_bit) && !clr) |=> (pending == $past(pending)));
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !(wr_sel && wr_bit)) |=> !pending);
   end else begin : g_mach
      logic unused_clr;
      assign unused_clr = clr;
      always_comb pending_d = wr_sel ? wr_bit : pending;

      assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_sel && wr_bit) |=> pending);
      assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_sel && !wr_bit) |=> !pending);
      assert_noclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_sel |=> (pending == $past(pending)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= pending_d;
   end
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
   parameter int unsigned        HART_COUNT = 4,
   parameter int unsigned        ADDR_W     = 8,
   parameter swi_pkg::swi_mode_e MODE       = swi_pkg::MODE_MACHINE
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_valid,
   input  logic                               bus_write,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [swi_pkg::LANES-1:0]          bus_be,
   input  logic [swi_pkg::DATA_W-1:0]         bus_wdata,
   output logic [swi_pkg::DATA_W-1:0]         bus_rdata,
   input  logic [HART_COUNT-1:0]              hart_clear,
   output logic [HART_COUNT-1:0]              soft_irq
);
   localparam int unsigned MIN_ADDR_W = $clog2(HART_COUNT * 4);

   if (HART_COUNT < 1) begin : g_bad_count
      $error("swi_bank: HART_COUNT must be at least 1");
   end
   if (ADDR_W < MIN_ADDR_W || ADDR_W < 3) begin : g_bad_addr
      $error("swi_bank: ADDR_W too narrow for HART_COUNT words");
   end

   logic                  hit;
   logic [HART_COUNT-1:0] sel;
   logic [HART_COUNT-1:0] pending;
   logic                  rd_en;
   logic                  rd_bit;
   logic                  unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[swi_pkg::DATA_W-1:1];

   swi_decode #(.HART_COUNT(HART_COUNT), .ADDR_W(ADDR_W)) i_decode (
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .hit       (hit),
      .sel       (sel)
   );

   for (genvar i = 0; i < HART_COUNT; i++) begin : g_hart
      swi_cell #(.MODE(MODE)) i_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (sel[i] && bus_write),
         .wr_bit  (bus_wdata[0]),
         .clr     (hart_clear[i]),
         .pending (pending[i])
      );
   end

   assign rd_en    = hit && !bus_write;
   assign soft_irq = pending;

   if (MODE == swi_pkg::MODE_SUPERVISOR) begin : g_rd_sup
      assign rd_bit = 1'b0;
      assert_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata == '0);
   end else begin : g_rd_mach
      assign rd_bit = |(pending & sel);
      assert_read_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && !(|(pending & sel))) |=> (bus_rdata == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= {{(swi_pkg::DATA_W-1){1'b0}}, rd_bit};
      else            bus_rdata <= '0;
   end

   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !hit) |=> (bus_rdata == '0));
   assert_rdata_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[swi_pkg::DATA_W-1:1] == '0);
endmodule

// File: tb/test_swi_bank.sv
module test_swi_bank;
   localparam int HN = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [3:0]    bus_be = '0;
   logic [31:0]   bus_wdata = '0;
   logic [HN-1:0] hart_clear = '0;
   logic [31:0]   m_rdata, s_rdata;
   logic [HN-1:0] m_irq, s_irq;

   logic [HN-1:0] m_exp = '0;
   logic [HN-1:0] s_exp = '0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   swi_bank #(.HART_COUNT(HN), .ADDR_W(AW), .MODE(swi_pkg::MODE_MACHINE)) i_swi_bank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(m_rdata), .hart_clear(hart_clear), .soft_irq(m_irq));

   swi_bank #(.HART_COUNT(HN), .ADDR_W(AW), .MODE(swi_pkg::MODE_SUPERVISOR)) i_swi_bank_sup (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(s_rdata), .hart_clear(hart_clear), .soft_irq(s_irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle (optionally with clear pulses), then compare everything with the model
   task automatic op(input string req, input logic wr, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic [3:0] be, input logic [HN-1:0] clr);
      logic ok;
      int idx;
      logic [31:0] m_rd_exp;
      logic [HN-1:0] set_mask;
      ok  = (be == 4'hF) && (a[1:0] == 2'b00) && (a < AW'(HN*4));
      idx = int'(a[AW-1:2]);
      m_rd_exp = '0;
      set_mask = '0;
      if (ok && !wr) m_rd_exp = {31'b0, m_exp[idx]};
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
      hart_clear = clr;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; hart_clear = '0;
      if (ok && wr) begin
         m_exp[idx] = d[0];
         if (d[0]) set_mask[idx] = 1'b1;
      end
      s_exp = (s_exp & ~clr) | set_mask;
      check({req, " machine irq"},    32'(m_irq), 32'(m_exp));
      check({req, " supervisor irq"}, 32'(s_irq), 32'(s_exp));
      if (!wr) begin
         check({req, " machine rdata"}, m_rdata, m_rd_exp);
         check({req, " R6 supervisor rdata"}, s_rdata, 32'h0);
      end
   endtask

   task automatic t_reset;
      check("R1 machine irq", 32'(m_irq), 0);
      check("R1 supervisor irq", 32'(s_irq), 0);
      check("R1 machine rdata", m_rdata, 0);
      check("R1 supervisor rdata", s_rdata, 0);
   endtask

   task automatic t_set_clear;
      op("R2 R3 R5 set hart1", 1, 8'h04, 32'h1, 4'hF, '0);
      op("R4 read hart1", 0, 8'h04, 32'h0, 4'hF, '0);
      op("R3 set hart2", 1, 8'h08, 32'h1, 4'hF, '0);
      op("R3 R5 zero write hart1", 1, 8'h04, 32'h0, 4'hF, '0);
      op("R4 read hart1 cleared", 0, 8'h04, 32'h0, 4'hF, '0);
      op("R4 read hart2", 0, 8'h08, 32'h0, 4'hF, '0);
      op("R2 set hart3", 1, 8'h0C, 32'h1, 4'hF, '0);
   endtask

   task automatic t_upper_bits;
      op("R12 upper ones clear", 1, 8'h08, 32'hFFFF_FFFE, 4'hF, '0);
      op("R12 upper only on zero", 1, 8'h00, 32'h8000_0000, 4'hF, '0);
      op("R12 R4 set with bit1", 1, 8'h00, 32'h0000_0003, 4'hF, '0);
      op("R4 read hart0 one", 0, 8'h00, 32'h0, 4'hF, '0);
   endtask

   task automatic t_misaligned;
      op("R9 misaligned write", 1, 8'h09, 32'h1, 4'hF, '0);
      op("R9 misaligned write2", 1, 8'h06, 32'h0, 4'hF, '0);
      op("R9 misaligned read", 0, 8'h01, 32'h0, 4'hF, '0);
   endtask

   task automatic t_unmapped;
      op("R10 write just past end", 1, 8'h10, 32'h1, 4'hF, '0);
      op("R10 write far", 1, 8'hFC, 32'h0, 4'hF, '0);
      op("R10 read past end", 0, 8'h10, 32'h0, 4'hF, '0);
   endtask

   task automatic t_partial;
      op("R11 low-lane write", 1, 8'h08, 32'h1, 4'h1, '0);
      op("R11 partial zero write", 1, 8'h00, 32'h0, 4'h7, '0);
      op("R11 partial read", 0, 8'h00, 32'h0, 4'h3, '0);
   endtask

   task automatic t_clear;
      op("R7 R8 clear all", 1, 8'h10, 32'h0, 4'hF, 4'hF);
      op("R7 set hart2", 1, 8'h08, 32'h1, 4'hF, '0);
      op("R7 set wins", 1, 8'h08, 32'h1, 4'hF, 4'b0100);
      op("R7 clear other hart during set", 1, 8'h04, 32'h1, 4'hF, 4'b0100);
      op("R8 read hart2 after clears", 0, 8'h08, 32'h0, 4'hF, 4'b0010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_upper_bits();
      t_misaligned();
      t_unmapped();
      t_partial();
      t_clear();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule